// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block is a memory-mapped master for the two-wire PHY management bus. Software writes a single 32-bit command word that holds the PHY address, the register address, the direction and, for writes, the 16-bit payload. The block then generates the management clock from the system clock and shifts out a complete Clause 22 frame. For a read, it releases the data line at the turnaround and captures the PHY's 16 reply bits.

The same word reports progress. A busy flag is set while a frame is on the wire. A read-valid flag is set once a read has finished and the low half holds the returned data. On every completed frame the block also latches a done flag in a cause register. Software can then sleep on an interrupt instead of polling: the interrupt output is the done flag gated by a mask bit. Only 5-bit PHY and register addresses exist, so extended-address accesses are not possible and the upper command bits carry nothing.

Top module: `mdio_c22_master`

## Requirements
- R1: After reset the command word reads 0, the cause and mask bits are 0, `irq` is low, `mdc` is low and `mdio_oe` is low.
- R2: The command word at offset 0x00 places the data in bits [15:0], the PHY address in bits [20:16], the register address in bits [25:21] and the operation in bit 26 (1 = read, 0 = write). Bits [31:27] of a written value have no effect, and bits [31:29] read as 0.
- R3: Bit 28 (busy) reads 1 from the cycle after a command is accepted until 128·HALF_CYC cycles have passed, then reads 0.
- R4: `mdc` is low whenever no frame is running. During a frame it starts low, and each level lasts HALF_CYC system cycles, so the first rising edge comes HALF_CYC cycles after acceptance.
- R5: A frame is 64 bit times sent MSB first: 32 ones, start 01, opcode 10 (read) or 01 (write), PHY address, register address, turnaround 10 and the 16 data bits (write). `mdio_o` changes only when `mdc` falls.
- R6: For a read, `mdio_oe` is low from the turnaround (bit time 46) to the end of the frame. The 16 data bits are sampled on the rising edges of `mdc`. At completion bits [15:0] hold them and bit 27 (read-valid) is 1.
- R7: Accepting any command clears read-valid, and a completed write leaves it at 0.
- R8: A write to the command word while busy is 1 is ignored. The running frame and the fields read back are unchanged.
- R9: Bit 4 of the cause register (0x7C) is set at completion of every frame. A write with bit 4 = 0 clears it, a write with bit 4 = 1 leaves it unchanged, and a completion on the same cycle as a clear wins.
- R10: Bit 4 of the mask register (0x80) is read/write, and `irq` is high exactly when both the cause bit and the mask bit are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | Management data from the line |
| irq | output | 1 | Masked transaction-done interrupt |

## Verification
A command accepted on a clock edge shows busy, the latched fields and the cleared read-valid in the command word from the next cycle. `mdc` first rises HALF_CYC cycles later, and bit time k spans cycles 2k·HALF_CYC to 2(k+1)·HALF_CYC−1 after acceptance. Busy falls, the cause bit sets, `irq` follows and the read data with read-valid appear together, 128·HALF_CYC cycles after acceptance. A behavioural model in the bench counts cycles from each accepting edge, derives every port value for that cycle and compares them at the falling clock edge. Inputs change a few nanoseconds after the rising edge, and the clear that races a completion is placed on exactly the finishing edge.

// File: rtl/mdio_c22_pkg.sv
package mdio_c22_pkg;

    localparam int REG_W      = 32;
    localparam int ADDR_W     = 8;

    localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h7C;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h80;

    localparam int DATA_W     = 16;
    localparam int ADR_W      = 5;
    localparam int PHY_LSB    = 16;
    localparam int RGA_LSB    = 21;
    localparam int OP_BIT     = 26;
    localparam int RVALID_BIT = 27;
    localparam int BUSY_BIT   = 28;
    localparam int DONE_BIT   = 4;

    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADR_W + 2 + DATA_W;
    localparam int TA_IDX     = PRE_BITS + 4 + 2 * ADR_W;
    localparam int DAT_IDX    = TA_IDX + 2;

    typedef enum logic {
        OP_WR = 1'b0,
        OP_RD = 1'b1
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e            op;
        logic [ADR_W-1:0]    regad;
        logic [ADR_W-1:0]    phyad;
        logic [DATA_W-1:0]   data;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_st_t;

    div_st_t s_d, s_q;
    logic    wrap;

    assign wrap = run && (s_q.cnt == CNT_LAST);

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc      = s_q.mdc;
    assign rise_stb = wrap && !s_q.mdc;
    assign fall_stb = wrap &&  s_q.mdc;

    // R4: the clock parks low whenever no frame runs
    a_r4_park_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_c22_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_BITS - 1);
    localparam logic [IW-1:0] IDX_TA   = IW'(TA_IDX);
    localparam logic [IW-1:0] IDX_DAT  = IW'(DAT_IDX);

    typedef struct packed {
        logic                  busy;
        logic [IW-1:0]         idx;
        logic [FRAME_BITS-1:0] sh;
        logic                  rd;
        logic [DATA_W-1:0]     cap;
    } eng_st_t;

    eng_st_t s_d, s_q;
    logic    is_rd;
    logic [FRAME_BITS-1:0] frame;

    always_comb begin
        is_rd = (cmd.op == OP_RD);
        frame = {{PRE_BITS{1'b1}}, 2'b01,
                 (is_rd ? 2'b10 : 2'b01),
                 cmd.phyad, cmd.regad, 2'b10,
                 (is_rd ? {DATA_W{1'b1}} : cmd.data)};
    end

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.idx  = '0;
                s_d.sh   = frame;
                s_d.rd   = is_rd;
                s_d.cap  = '0;
            end
        end else begin
            if (rise_stb && s_q.rd && (s_q.idx >= IDX_DAT))
                s_d.cap = {s_q.cap[DATA_W-2:0], mdio_i};
            if (fall_stb) begin
                if (s_q.idx == IDX_LAST) begin
                    s_d.busy = 1'b0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                    s_d.sh  = {s_q.sh[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign done    = s_q.busy && fall_stb && (s_q.idx == IDX_LAST);
    assign rd_data = s_q.cap;
    assign mdio_o  = s_q.busy ? s_q.sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = s_q.busy && !(s_q.rd && (s_q.idx >= IDX_TA));

    // R5: the line holds its value across a rising clock edge
    a_r5_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && rise_stb) |=> $stable(mdio_o));

    // R6: a read frame never drives the line once the turnaround is reached
    a_r6_release_ta: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.rd && fall_stb && (s_q.idx == IDX_TA - 1'b1)) |=> !mdio_oe);

endmodule

// File: rtl/mdio_c22_master.sv
module mdio_c22_master
    import mdio_c22_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i,
    output logic              irq
);
    typedef struct packed {
        mdio_cmd_t cmd;
        logic      rvalid;
        logic      cause;
        logic      mask;
    } top_st_t;

    top_st_t           s_d, s_q;
    mdio_cmd_t         new_cmd;
    logic              start;
    logic              eng_busy, eng_done;
    logic [DATA_W-1:0] eng_data;
    logic              rise_stb, fall_stb;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_W-1:RVALID_BIT];

    assign start = reg_we && (reg_addr == OFS_CMD) && !eng_busy;

    always_comb begin
        new_cmd.op    = mdio_op_e'(reg_wdata[OP_BIT]);
        new_cmd.regad = reg_wdata[RGA_LSB +: ADR_W];
        new_cmd.phyad = reg_wdata[PHY_LSB +: ADR_W];
        new_cmd.data  = reg_wdata[DATA_W-1:0];
    end

    mdio_mdc_div #(.HALF_CYC(HALF_CYC)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (eng_busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_eng u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (new_cmd),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (eng_busy),
        .done     (eng_done),
        .rd_data  (eng_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.cmd    = new_cmd;
            s_d.rvalid = 1'b0;
        end
        if (eng_done && (s_q.cmd.op == OP_RD)) begin
            s_d.cmd.data = eng_data;
            s_d.rvalid   = 1'b1;
        end
        if (reg_we && (reg_addr == OFS_CAUSE) && !reg_wdata[DONE_BIT])
            s_d.cause = 1'b0;
        if (eng_done)
            s_d.cause = 1'b1;
        if (reg_we && (reg_addr == OFS_MASK))
            s_d.mask = reg_wdata[DONE_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD: begin
                reg_rdata[DATA_W-1:0]         = s_q.cmd.data;
                reg_rdata[PHY_LSB +: ADR_W]   = s_q.cmd.phyad;
                reg_rdata[RGA_LSB +: ADR_W]   = s_q.cmd.regad;
                reg_rdata[OP_BIT]             = s_q.cmd.op;
                reg_rdata[RVALID_BIT]         = s_q.rvalid;
                reg_rdata[BUSY_BIT]           = eng_busy;
            end
            OFS_CAUSE: reg_rdata[DONE_BIT] = s_q.cause;
            OFS_MASK:  reg_rdata[DONE_BIT] = s_q.mask;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = s_q.cause && s_q.mask;

    // R4: no clock activity outside a frame
    a_r4_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdc);

    // R8: a command written during a frame leaves the latched fields alone
    a_r8_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == OFS_CMD) && eng_busy && !eng_done) |=> $stable(s_q.cmd));

    // R9: a finished frame always leaves the done cause set
    a_r9_done_sets_cause: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> s_q.cause);

    // R6: read-valid rises only as a read frame ends
    a_r6_rvalid_at_read_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.rvalid) |-> ($fell(eng_busy) && (s_q.cmd.op == OP_RD)));

    // R7: an accepted command starts with read-valid low
    a_r7_accept_clears_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !s_q.rvalid);

endmodule

// File: tb/sim_mdio_c22_master.sv
module sim_mdio_c22_master;

    localparam int HALF  = 4;
    localparam int TOTAL = 128 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic        mdi = 1'b1;
    logic [31:0] rdata;
    logic        mdc, mdo, moe, irq;

    always #10 clk = ~clk;

    mdio_c22_master #(.HALF_CYC(HALF)) u0 (
        .clk (clk), .rst_n (rst_n), .reg_we (we), .reg_addr (addr),
        .reg_wdata (wdata), .reg_rdata (rdata), .mdc (mdc), .mdio_o (mdo),
        .mdio_oe (moe), .mdio_i (mdi), .irq (irq)
    );

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit          m_busy, m_rvalid, m_cause, m_mask, m_op;
    logic [4:0]  m_phy, m_reg;
    logic [15:0] m_data;
    logic [15:0] m_resp = 16'h0;
    logic [63:0] m_frame;
    int          m_t;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit was_busy, fin;
        was_busy = m_busy;
        fin = 1'b0;
        if (!rst_n) begin
            m_busy = 0; m_rvalid = 0; m_cause = 0; m_mask = 0; m_op = 0;
            m_phy = 0; m_reg = 0; m_data = 0; m_t = 0; m_frame = '1;
        end else begin
            if (m_busy) begin
                if (m_t == TOTAL - 1) begin
                    m_busy = 0;
                    fin = 1'b1;
                end else begin
                    m_t++;
                end
            end
            if (we && addr == 8'h00 && !was_busy) begin
                m_busy = 1; m_t = 0; m_rvalid = 0;
                m_op = wdata[26]; m_reg = wdata[25:21]; m_phy = wdata[20:16];
                m_data = wdata[15:0];
                m_frame = {32'hFFFF_FFFF, 2'b01, (m_op ? 2'b10 : 2'b01),
                           m_phy, m_reg, 2'b10, m_data};
            end
            if (fin && m_op) begin
                m_data = m_resp;
                m_rvalid = 1;
            end
            if (we && addr == 8'h7C && !wdata[4]) m_cause = 0;
            if (fin) m_cause = 1;
            if (we && addr == 8'h80) m_mask = wdata[4];
        end
    end

    // per-cycle comparison and line responder, away from the active edge
    always @(negedge clk) begin
        int idx;
        bit exp_oe;
        idx = m_t / (2 * HALF);
        if (rst_n) begin
            check("R4 mdc level", mdc, (m_busy && ((m_t / HALF) % 2 == 1)));
            exp_oe = m_busy && !(m_op && idx >= 46);
            check("R6 mdio_oe", moe, exp_oe);
            if (exp_oe) check("R5 mdio_o frame bit", mdo, m_frame[63 - idx]);
            check("R10 irq", irq, (m_cause && m_mask));
            if (addr == 8'h00)
                check("R2 R3 command word", rdata,
                      {3'b000, m_busy, m_rvalid, m_op, m_reg, m_phy, m_data});
        end
        mdi = (m_busy && m_op && idx >= 48) ? m_resp[63 - idx] : 1'b1;
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #4;
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #4;
        we = 1'b0; addr = 8'h00; wdata = 32'h0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #4;
        addr = a;
        #2;
        check(tag, rdata, exp);
        addr = 8'h00;
    endtask

    task automatic wait_idle();
        forever begin
            @(negedge clk);
            if (!m_busy) break;
        end
    endtask

    task automatic run_tests();
        repeat (3) @(posedge clk);
        #4 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset command word", rdata, 32'h0);
        check("R1 reset mdc", mdc, 1'b0);
        check("R1 reset mdio_oe", moe, 1'b0);
        check("R1 reset irq", irq, 1'b0);
        rd_chk(8'h7C, 32'h0, "R1 reset cause");
        rd_chk(8'h80, 32'h0, "R1 reset mask");

        wr(8'h80, 32'h0000_0010);
        rd_chk(8'h80, 32'h0000_0010, "R10 mask readback");

        // write frame with junk in the upper bits
        wr(8'h00, {3'b111, 1'b1, 1'b1, 1'b0, 5'h13, 5'h0A, 16'hBEEF});
        rd_chk(8'h00, {3'b000, 1'b1, 1'b0, 1'b0, 5'h13, 5'h0A, 16'hBEEF}, "R2 fields, upper bits ignored");
        wait_idle();
        rd_chk(8'h7C, 32'h0000_0010, "R9 cause set at completion");
        check("R10 irq with cause and mask", irq, 1'b1);
        wr(8'h7C, 32'hFFFF_FFFF);
        rd_chk(8'h7C, 32'h0000_0010, "R9 write of one keeps cause");
        wr(8'h7C, 32'hFFFF_FFEF);
        rd_chk(8'h7C, 32'h0, "R9 write of zero clears cause");
        check("R10 irq low after clear", irq, 1'b0);

        // read frame, with an attempted command while busy
        m_resp = 16'h5A3C;
        wr(8'h00, {5'b00000, 1'b1, 5'h02, 5'h03, 16'h0000});
        repeat (20) @(posedge clk);
        wr(8'h00, {5'b00000, 1'b0, 5'h1F, 5'h1F, 16'h1234});
        rd_chk(8'h00, {3'b000, 1'b1, 1'b0, 1'b1, 5'h02, 5'h03, 16'h0000}, "R8 command during busy ignored");
        wait_idle();
        rd_chk(8'h00, {3'b000, 1'b0, 1'b1, 1'b1, 5'h02, 5'h03, 16'h5A3C}, "R6 read data and read-valid");

        // completion racing a clear of the cause
        wr(8'h7C, 32'h0);
        m_resp = 16'h8001;
        wr(8'h00, {5'b00000, 1'b1, 5'h1F, 5'h1F, 16'hFFFF});
        forever begin
            @(posedge clk); #1;
            if (m_busy && m_t == TOTAL - 1) break;
        end
        #3;
        we = 1'b1; addr = 8'h7C; wdata = 32'h0;
        @(posedge clk); #4;
        we = 1'b0; addr = 8'h00;
        rd_chk(8'h7C, 32'h0000_0010, "R9 completion wins over clear");
        rd_chk(8'h00, {3'b000, 1'b0, 1'b1, 1'b1, 5'h1F, 5'h1F, 16'h8001}, "R6 read data edge pattern");

        // a new write clears read-valid and leaves it low
        wr(8'h00, {5'b00000, 1'b0, 5'h00, 5'h00, 16'h0000});
        rd_chk(8'h00, {3'b000, 1'b1, 1'b0, 1'b0, 5'h00, 5'h00, 16'h0000}, "R7 accept clears read-valid");
        wait_idle();
        rd_chk(8'h00, 32'h0, "R7 write completion keeps read-valid low");

        // masked interrupt
        wr(8'h80, 32'h0);
        rd_chk(8'h7C, 32'h0000_0010, "R10 cause still set while masked");
        check("R10 irq masked", irq, 1'b0);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog R3 run did not finish act=%0d exp=%0d", 100000, 0);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule